// File: doc/BRIEF.md
# Mailbox Aperture with Ownership Handoff

This block is a 256-bit register window shared by two agents: a requester (a virtual function) and a responder (a physical function). The window is eight 32-bit dwords. Each agent has its own dword-addressed register port with a write strobe, a read strobe and registered read data. The top bit of the last dword is an ownership flag. A value of 0 means the requester owns the window and 1 means the responder owns it.

The requester fills the payload dwords and then writes the last dword, which holds the control header. That write is the doorbell. The hardware sets the ownership flag to the responder as a side effect, and no separate trigger exists. The responder reads the request and writes its reply header into the last dword. That write returns ownership to the requester, whatever bit 31 of the write data holds.

The header fields are message type in bits [2:0], version in [5:3], direction in bit 7 (0 request, 1 response), status in [15:8] (0 success), reset-function request in bit 24 and owner in bit 31. The block stores all of these verbatim apart from the owner bit. While the requester's function-reset input is high, a read of the last dword returns all ones. Software uses this pattern to detect a function in reset.

Top module: `mbox_window`

## Requirements
- R1: After reset, all eight dwords hold 0 (so the requester owns the window), both read-data outputs are 0 and `req_ignored` is 0.
- R2: A read strobe with address A in cycle N makes that port's read data equal dword A as stored before any write of cycle N, visible after the clock edge ending cycle N. The read data holds its value while no read strobe is given.
- R3: An accepted requester write to dword 7 stores write-data bits [30:0] verbatim and sets bit 31 (owner) to 1, even when write-data bit 31 is 0.
- R4: A responder write to dword 7 stores write-data bits [30:0] verbatim and clears bit 31 to 0, even when write-data bit 31 is 1. This applies whoever owns the window.
- R5: A requester write to any dword while bit 31 of dword 7 is 1 is dropped and leaves the window unchanged. `req_ignored` is 1 during the cycle after each dropped write and 0 otherwise.
- R6: While `fn_reset` is 1 in the cycle of a read strobe to dword 7, either port returns 0xFFFFFFFF. Reads of dwords 0 to 6 are unaffected, and the stored contents are unchanged.
- R7: When both ports write the same dword in one cycle, the responder's value is stored. When they write different dwords, both writes take effect.
- R8: While the requester owns the window, requester writes to dwords 0 to 6 store their data. Responder writes to dwords 0 to 6 store their data at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fn_reset | input | 1 | Requester function held in reset; last dword reads as all ones |
| req_wr_en | input | 1 | Requester write strobe |
| req_rd_en | input | 1 | Requester read strobe |
| req_addr | input | 3 | Requester dword index |
| req_wdata | input | 32 | Requester write data |
| req_rdata | output | 32 | Requester read data, one-cycle latency |
| req_ignored | output | 1 | Pulses the cycle after a dropped requester write |
| rsp_wr_en | input | 1 | Responder write strobe |
| rsp_rd_en | input | 1 | Responder read strobe |
| rsp_addr | input | 3 | Responder dword index |
| rsp_wdata | input | 32 | Responder write data |
| rsp_rdata | output | 32 | Responder read data, one-cycle latency |

## Verification
The assertions assume that strobes and addresses are known (not X) while reset is released. They also assume that `fn_reset` is a level held over whole cycles, not a glitch within a cycle. Both ports' inputs are assumed to change only away from the capturing edge. The bench drives every input on the falling edge from single-cycle tasks and returns all strobes to 0 after each operation. Collisions happen only where a task creates them on purpose, so every input the assertions see is a settled, defined value.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Source chosen for one stored dword on a clock edge.
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_REQ  = 2'd1,
    SRC_RSP  = 2'd2
  } wsrc_e;

  // Responder has priority over requester on the same dword.
  function automatic wsrc_e word_source(input logic req_hit, input logic rsp_hit);
    if (rsp_hit)      return SRC_RSP;
    else if (req_hit) return SRC_REQ;
    else              return SRC_HOLD;
  endfunction

  // Replace the top bit of a dword with a forced ownership value.
  function automatic logic [31:0] with_owner(input logic [31:0] data, input logic owner);
    return {owner, data[30:0]};
  endfunction

endpackage

// File: rtl/mbox_gate.sv
module mbox_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic rsp_owns,
  output logic accept,
  output logic drop,
  output logic ignored
);

  assign accept = wr_en && !rsp_owns;
  assign drop   = wr_en &&  rsp_owns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ignored <= 1'b0;
    else        ignored <= drop;
  end

  AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ignored); // R5
  AST_FLAG_ONLY_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ignored |-> $past(wr_en && rsp_owns)); // R5

endmodule

// File: rtl/mbox_store.sv
module mbox_store
  import mbox_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned NWORDS = 8,
  parameter int unsigned AW     = $clog2(NWORDS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_we,
  input  logic [AW-1:0]              req_addr,
  input  logic [DW-1:0]              req_wdata,
  input  logic                       rsp_we,
  input  logic [AW-1:0]              rsp_addr,
  input  logic [DW-1:0]              rsp_wdata,
  output logic [NWORDS-1:0][DW-1:0]  words,
  output logic                       rsp_owns
);

  localparam int unsigned LAST = NWORDS - 1;

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    logic  req_hit, rsp_hit;
    wsrc_e src;
    assign req_hit = req_we && (req_addr == AW'(i));
    assign rsp_hit = rsp_we && (rsp_addr == AW'(i));
    assign src     = word_source(req_hit, rsp_hit);

    if (i == LAST) begin : g_hdr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) words[i] <= '0;
        else begin
          case (src)
            SRC_RSP: words[i] <= with_owner(rsp_wdata, 1'b0);
            SRC_REQ: words[i] <= with_owner(req_wdata, 1'b1);
            default: ;
          endcase
        end
      end
    end else begin : g_pay
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) words[i] <= '0;
        else begin
          case (src)
            SRC_RSP: words[i] <= rsp_wdata;
            SRC_REQ: words[i] <= req_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  assign rsp_owns = words[LAST][DW-1];

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_we && !rsp_we) |=> $stable(words)); // R8

endmodule

// File: rtl/mbox_rdport.sv
module mbox_rdport #(
  parameter int unsigned DW     = 32,
  parameter int unsigned NWORDS = 8,
  parameter int unsigned AW     = $clog2(NWORDS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_en,
  input  logic [AW-1:0]             addr,
  input  logic                      fn_reset,
  input  logic [NWORDS-1:0][DW-1:0] words,
  output logic [DW-1:0]             rdata
);

  logic mask_hit;
  assign mask_hit = fn_reset && (addr == AW'(NWORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rdata <= '0;
    else if (rd_en) begin
      if (mask_hit)       rdata <= '1;
      else                rdata <= words[addr];
    end
  end

  AST_RESET_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && fn_reset && addr == AW'(NWORDS - 1)) |=> (rdata == '1)); // R6
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R2

endmodule

// File: rtl/mbox_window.sv
module mbox_window #(
  parameter int unsigned DW     = 32,
  parameter int unsigned NWORDS = 8,
  parameter int unsigned AW     = $clog2(NWORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fn_reset,
  input  logic          req_wr_en,
  input  logic          req_rd_en,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] req_rdata,
  output logic          req_ignored,
  input  logic          rsp_wr_en,
  input  logic          rsp_rd_en,
  input  logic [AW-1:0] rsp_addr,
  input  logic [DW-1:0] rsp_wdata,
  output logic [DW-1:0] rsp_rdata
);

  localparam logic [AW-1:0] LAST_A = AW'(NWORDS - 1);

  logic                      rsp_owns;
  logic                      req_accept;
  logic                      req_drop;
  logic [NWORDS-1:0][DW-1:0] words;
  logic                      req_doorbell;
  logic                      rsp_reply;

  mbox_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (req_wr_en),
    .rsp_owns(rsp_owns),
    .accept  (req_accept),
    .drop    (req_drop),
    .ignored (req_ignored)
  );

  mbox_store #(.DW(DW), .NWORDS(NWORDS), .AW(AW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_we   (req_accept),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rsp_we   (rsp_wr_en),
    .rsp_addr (rsp_addr),
    .rsp_wdata(rsp_wdata),
    .words    (words),
    .rsp_owns (rsp_owns)
  );

  mbox_rdport #(.DW(DW), .NWORDS(NWORDS), .AW(AW)) u_req_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (req_rd_en),
    .addr    (req_addr),
    .fn_reset(fn_reset),
    .words   (words),
    .rdata   (req_rdata)
  );

  mbox_rdport #(.DW(DW), .NWORDS(NWORDS), .AW(AW)) u_rsp_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rsp_rd_en),
    .addr    (rsp_addr),
    .fn_reset(fn_reset),
    .words   (words),
    .rdata   (rsp_rdata)
  );

  assign req_doorbell = req_accept && (req_addr == LAST_A);
  assign rsp_reply    = rsp_wr_en  && (rsp_addr == LAST_A);

  AST_DOORBELL_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (req_doorbell && !rsp_reply) |=> rsp_owns); // R3
  AST_OWNER_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_owns) |-> $past(req_doorbell)); // R3
  AST_REPLY_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_reply |=> !rsp_owns); // R4
  AST_DROP_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_drop && !rsp_wr_en) |=> $stable(words)); // R5

endmodule

// File: tb/mbox_window_test.sv
module mbox_window_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fn_reset;
  logic        req_wr_en, req_rd_en, rsp_wr_en, rsp_rd_en;
  logic [2:0]  req_addr, rsp_addr;
  logic [31:0] req_wdata, rsp_wdata;
  logic [31:0] req_rdata, rsp_rdata;
  logic        req_ignored;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mbox_window uut (
    .clk(clk), .rst_n(rst_n), .fn_reset(fn_reset),
    .req_wr_en(req_wr_en), .req_rd_en(req_rd_en), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_rdata(req_rdata), .req_ignored(req_ignored),
    .rsp_wr_en(rsp_wr_en), .rsp_rd_en(rsp_rd_en), .rsp_addr(rsp_addr),
    .rsp_wdata(rsp_wdata), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle_strobes();
    req_wr_en = 0; req_rd_en = 0; rsp_wr_en = 0; rsp_rd_en = 0;
  endtask

  task automatic req_write(input logic [2:0] a, input logic [31:0] d);
    req_addr = a; req_wdata = d; req_wr_en = 1;
    @(negedge clk); idle_strobes();
  endtask

  task automatic rsp_write(input logic [2:0] a, input logic [31:0] d);
    rsp_addr = a; rsp_wdata = d; rsp_wr_en = 1;
    @(negedge clk); idle_strobes();
  endtask

  task automatic req_read(input logic [2:0] a, output logic [31:0] d);
    req_addr = a; req_rd_en = 1;
    @(negedge clk); idle_strobes(); d = req_rdata;
  endtask

  task automatic rsp_read(input logic [2:0] a, output logic [31:0] d);
    rsp_addr = a; rsp_rd_en = 1;
    @(negedge clk); idle_strobes(); d = rsp_rdata;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    check("R1 req_rdata after reset", req_rdata, 32'h0);
    check("R1 rsp_rdata after reset", rsp_rdata, 32'h0);
    check("R1 req_ignored after reset", {31'h0, req_ignored}, 32'h0);
    for (int i = 0; i < 8; i++) begin
      req_read(3'(i), v);
      check("R1 dword zero after reset", v, 32'h0);
    end
  endtask

  task automatic t_payload();
    logic [31:0] v;
    for (int i = 0; i < 7; i++) req_write(3'(i), 32'hA5000000 + 32'(i * 17));
    for (int i = 0; i < 7; i++) begin
      rsp_read(3'(i), v);
      check("R8 requester payload seen by responder", v, 32'hA5000000 + 32'(i * 17));
    end
    rsp_write(3'd5, 32'h0BADF00D);
    req_read(3'd5, v);
    check("R8 responder payload write", v, 32'h0BADF00D);
    // R2: read data held while no strobe is given
    @(negedge clk);
    check("R2 rdata holds without strobe", req_rdata, 32'h0BADF00D);
    // R2: read and write of the same dword in one cycle returns the old value
    req_addr = 3'd1; req_wdata = 32'h11112222; req_wr_en = 1; req_rd_en = 1;
    @(negedge clk); idle_strobes();
    check("R2 read-before-write same cycle", req_rdata, 32'hA5000011);
    req_read(3'd1, v);
    check("R2 later read sees write", v, 32'h11112222);
  endtask

  task automatic t_handoff();
    logic [31:0] v;
    req_write(3'd7, 32'h01000001);
    check("R3 doorbell not ignored", {31'h0, req_ignored}, 32'h0);
    rsp_read(3'd7, v);
    check("R3 owner set by doorbell", v, 32'h81000001);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    req_write(3'd2, 32'hDEADBEEF);
    check("R5 ignored pulse on payload", {31'h0, req_ignored}, 32'h1);
    @(negedge clk);
    check("R5 ignored pulse ends", {31'h0, req_ignored}, 32'h0);
    rsp_read(3'd2, v);
    check("R5 payload unchanged", v, 32'hA5000022);
    req_write(3'd7, 32'h00000002);
    check("R5 ignored pulse on header", {31'h0, req_ignored}, 32'h1);
    rsp_read(3'd7, v);
    check("R5 header unchanged", v, 32'h81000001);
  endtask

  task automatic t_response();
    logic [31:0] v;
    rsp_write(3'd7, 32'h80000081);
    req_read(3'd7, v);
    check("R4 reply clears owner", v, 32'h00000081);
    req_write(3'd2, 32'h12345678);
    check("R4 requester accepted after reply", {31'h0, req_ignored}, 32'h0);
    req_read(3'd2, v);
    check("R4 payload write after reply", v, 32'h12345678);
    // Handoff with write-data bit 31 already set, then reply with bit 31 clear
    req_write(3'd7, 32'h80000002);
    rsp_read(3'd7, v);
    check("R3 owner set with bit31 in data", v, 32'h80000002);
    rsp_write(3'd7, 32'h00000282);
    rsp_read(3'd7, v);
    check("R4 reply with bit31 clear", v, 32'h00000282);
  endtask

  task automatic t_fn_reset();
    logic [31:0] v;
    fn_reset = 1;
    req_read(3'd7, v);
    check("R6 requester sees all ones", v, 32'hFFFFFFFF);
    rsp_read(3'd7, v);
    check("R6 responder sees all ones", v, 32'hFFFFFFFF);
    req_read(3'd2, v);
    check("R6 payload unaffected", v, 32'h12345678);
    fn_reset = 0;
    req_read(3'd7, v);
    check("R6 header kept through function reset", v, 32'h00000282);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    req_addr = 3'd3; req_wdata = 32'h33333333; req_wr_en = 1;
    rsp_addr = 3'd3; rsp_wdata = 32'hCCCCCCCC; rsp_wr_en = 1;
    @(negedge clk); idle_strobes();
    req_read(3'd3, v);
    check("R7 responder wins same dword", v, 32'hCCCCCCCC);
    req_addr = 3'd4; req_wdata = 32'h44440000; req_wr_en = 1;
    rsp_addr = 3'd6; rsp_wdata = 32'h66660000; rsp_wr_en = 1;
    @(negedge clk); idle_strobes();
    req_read(3'd4, v);
    check("R7 requester write on other dword", v, 32'h44440000);
    req_read(3'd6, v);
    check("R7 responder write on other dword", v, 32'h66660000);
    req_addr = 3'd7; req_wdata = 32'h00000001; req_wr_en = 1;
    rsp_addr = 3'd7; rsp_wdata = 32'h80000181; rsp_wr_en = 1;
    @(negedge clk); idle_strobes();
    req_read(3'd7, v);
    check("R7 reply wins over doorbell", v, 32'h00000181);
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; fn_reset = 0;
    req_addr = 0; rsp_addr = 0; req_wdata = 0; rsp_wdata = 0;
    idle_strobes();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_payload();
    t_handoff();
    t_ignored();
    t_response();
    t_fn_reset();
    t_collide();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule